// File: doc/BRIEF.md
# Partial-Word Load/Store Merger

This unit carries out the four partial-word memory operations of a little-endian 32-bit core: the left and right loads that fold part of a memory word into a register value, and the left and right stores that fold part of a register value into a memory word. The issuing pipeline gives a base register value, a signed 16-bit displacement, the destination or source register index, the current register contents and an operation code. The unit forms the effective address, reads the enclosing aligned word over a single-cycle memory port, and merges bytes according to the low two address bits.

Loads finish two cycles after they are accepted. The unit drives a register write port with the merged value and pulses `done`. Stores finish one cycle later, after the merged word has been written back to the same aligned address. Any value of the low address bits is legal for these four operations. No alignment fault is ever raised. While an operation is in flight the unit reports busy and ignores new requests.

Top module: `partial_word_merge`

## Requirements
- R1: The effective address is `base + sign_extend(offset)`. One cycle after an accepted start, `mem_rd` is high for exactly one cycle and `mem_addr` is the effective address with its two low bits forced to 0. All four values of the low bits are accepted and none of them causes a fault.
- R2: Operation code: bit 1 selects store (1) or load (0), and bit 0 selects right (1) or left (0). A start is accepted only when `busy` is low. A start seen while `busy` is high, including in the completion cycle, has no effect. `busy` is high from the cycle after acceptance through the completion cycle.
- R3: Load-left (code 0), with k = EA[1:0] and s = (3−k)·8: result = (mem << s) | (rt & ~(0xFFFFFFFF << s)).
- R4: Load-right (code 1), with s = k·8: result = (mem >> s) | (rt & ~(0xFFFFFFFF >> s)).
- R5: Store-left (code 2), with s = (3−k)·8: written word = (mem & ~(0xFFFFFFFF >> s)) | (rt >> s).
- R6: Store-right (code 3), with s = k·8: written word = (mem & ~(0xFFFFFFFF << s)) | (rt << s).
- R7: A load completes two cycles after acceptance. In that cycle `reg_we` is high with `reg_idx` equal to the requested index and `reg_wdata` the merged value, and `done` is high. A load never asserts `mem_wr`.
- R8: A load whose register index is 0 still completes with `done`, but `reg_we` stays low.
- R9: A store completes three cycles after acceptance. In that cycle `mem_wr` is high at the same address that was read, with the merged word on `mem_wdata`, and `done` is high. A store never asserts `reg_we`. Memory returns read data in the cycle after `mem_rd`.
- R10: While `rst_n` is low, at a clock edge `busy`, `done`, `mem_rd`, `mem_wr` and `reg_we` all go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request an operation (taken only when idle) |
| op | input | 2 | Operation code: bit1 store, bit0 right |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| rt_idx | input | 5 | Register index for the load result |
| rt_val | input | 32 | Current register contents |
| mem_addr | output | 32 | Aligned memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Merged store word |
| reg_we | output | 1 | Register write enable |
| reg_idx | output | 5 | Register write index |
| reg_wdata | output | 32 | Merged load value |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Completion pulse |

## Verification
Two events can fall in the same cycle: a new request on `start`, and the completion of the previous operation, whose `done` pulse may also carry the store write. The bench keeps `start` high, with operand fields changing every cycle, throughout busy operations and through their completion cycle. It then checks that none of those requests starts a second read, and that the memory contents seen by later loads reflect only the accepted operations. A behavioural reference model runs alongside the design and is compared with every output on every clock.

// File: rtl/pwm_pkg.sv
// Shared types for the partial-word merger.
// Assumes a 2-bit operation code: bit 1 = store, bit 0 = right form.
package pwm_pkg;

    typedef enum logic [1:0] {
        OP_LD_LEFT  = 2'd0,
        OP_LD_RIGHT = 2'd1,
        OP_ST_LEFT  = 2'd2,
        OP_ST_RIGHT = 2'd3
    } merge_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_MERGE = 2'd2,
        ST_WRITE = 2'd3
    } merge_state_e;

endpackage

// File: rtl/pwm_addr_gen.sv
// Effective address generation.
// Adds the sign-extended displacement to the base. Outputs the word-aligned
// address and the byte lane within the word. Purely combinational.
module pwm_addr_gen #(
    parameter  int ADDR_W = 32,
    parameter  int OFF_W  = 16,
    parameter  int LANES  = 4,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] aligned,
    output logic [LANE_W-1:0] lane
);
    logic [ADDR_W-1:0] ea;

    // Sum of base and sign-extended displacement.
    always_comb begin
        ea = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
    end

    // Split the effective address into word address and lane.
    always_comb begin
        aligned = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        lane    = ea[LANE_W-1:0];
    end
endmodule

// File: rtl/pwm_lane_merge.sv
// Byte-lane merge network.
// Each output lane picks either a shifted byte of the source word or the
// same lane of the word being preserved. The choice depends on the operation
// and the lane offset. Assumes little-endian byte numbering. Combinational.
module pwm_lane_merge
    import pwm_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int BYTE_W = 8,
    localparam int LANES  = DATA_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int LAST   = LANES - 1
) (
    input  merge_op_e         op,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_b;

        // Select the byte that lands in output lane g.
        always_comb begin
            int s;
            int src;
            s      = 0;
            src    = 0;
            lane_b = rt_val[g*BYTE_W +: BYTE_W];
            unique case (op)
                OP_LD_LEFT: begin
                    s   = LAST - int'(lane);
                    src = g - s;
                    lane_b = (src >= 0) ? BYTE_W'(mem_word >> (src*BYTE_W))
                                        : rt_val[g*BYTE_W +: BYTE_W];
                end
                OP_LD_RIGHT: begin
                    s   = int'(lane);
                    src = g + s;
                    lane_b = (src <= LAST) ? BYTE_W'(mem_word >> (src*BYTE_W))
                                           : rt_val[g*BYTE_W +: BYTE_W];
                end
                OP_ST_LEFT: begin
                    s   = LAST - int'(lane);
                    src = g + s;
                    lane_b = (src <= LAST) ? BYTE_W'(rt_val >> (src*BYTE_W))
                                           : mem_word[g*BYTE_W +: BYTE_W];
                end
                OP_ST_RIGHT: begin
                    s   = int'(lane);
                    src = g - s;
                    lane_b = (src >= 0) ? BYTE_W'(rt_val >> (src*BYTE_W))
                                        : mem_word[g*BYTE_W +: BYTE_W];
                end
                default: lane_b = rt_val[g*BYTE_W +: BYTE_W];
            endcase
        end

        assign merged[g*BYTE_W +: BYTE_W] = lane_b;
    end
endmodule

// File: rtl/pwm_ctrl.sv
// Sequencer for the read / merge / write steps.
// Accepts a request only when idle. Loads end in the merge step and stores
// end in a following write step. Assumes memory data arrives the cycle
// after the read strobe.
module pwm_ctrl
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_store,
    output logic accept,
    output logic mem_rd,
    output logic merge_cyc,
    output logic mem_wr,
    output logic done,
    output logic busy
);
    merge_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  state_d = ST_MERGE;
            ST_MERGE: state_d = is_store ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Strobes decoded from the current state.
    always_comb begin
        accept    = (state_q == ST_IDLE) && start;
        mem_rd    = (state_q == ST_READ);
        merge_cyc = (state_q == ST_MERGE);
        mem_wr    = (state_q == ST_WRITE);
        done      = (merge_cyc && !is_store) || mem_wr;
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/partial_word_merge.sv
// Partial-word load/store merger, top level.
// Latches the request on acceptance and reads the aligned word. It then
// either writes the merged value to the register port (loads) or writes the
// merged word back to memory (stores). Register index 0 is never written.
module partial_word_merge
    import pwm_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    parameter  int OFF_W  = 16,
    parameter  int RIDX_W = 5,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [RIDX_W-1:0] rt_idx,
    input  logic [DATA_W-1:0] rt_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              reg_we,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              busy,
    output logic              done
);
    logic [ADDR_W-1:0] aligned_d;
    logic [LANE_W-1:0] lane_d, lane_q;
    merge_op_e         op_q;
    logic [DATA_W-1:0] rt_q, merged, wdata_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RIDX_W-1:0] idx_q;
    logic              accept, merge_cyc;

    pwm_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_addr (
        .base    (base),
        .offset  (offset),
        .aligned (aligned_d),
        .lane    (lane_d)
    );

    pwm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_store  (op_q[1]),
        .accept    (accept),
        .mem_rd    (mem_rd),
        .merge_cyc (merge_cyc),
        .mem_wr    (mem_wr),
        .done      (done),
        .busy      (busy)
    );

    pwm_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .op       (op_q),
        .lane     (lane_q),
        .rt_val   (rt_q),
        .mem_word (mem_rdata),
        .merged   (merged)
    );

    // Capture the request fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_LD_LEFT;
            lane_q <= '0;
            rt_q   <= '0;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (accept) begin
            op_q   <= merge_op_e'(op);
            lane_q <= lane_d;
            rt_q   <= rt_val;
            addr_q <= aligned_d;
            idx_q  <= rt_idx;
        end
    end

    // Hold the merged store word for the write step.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wdata_q <= '0;
        else if (merge_cyc && op_q[1])  wdata_q <= merged;
    end

    // Output assignments.
    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        reg_idx   = idx_q;
        reg_wdata = merged;
        reg_we    = merge_cyc && !op_q[1] && (idx_q != '0);
    end
endmodule

// File: rtl/partial_word_merge_checks.sv
// Protocol checker for the partial-word merger, bound to every instance.
// Assumes the same synchronous active-low reset as the design.
module partial_word_merge_checks #(
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 5,
    parameter int LANE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              reg_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [RIDX_W-1:0] reg_idx
);
    p_read_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> mem_rd);

    p_aligned_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[LANE_W-1:0] == '0));

    p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_load_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (done && !mem_wr));

    p_no_zero_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_idx != '0));

    p_write_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && done));

    p_write_same_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == $past(mem_addr, 2)));
endmodule

bind partial_word_merge partial_word_merge_checks #(
    .ADDR_W (ADDR_W),
    .RIDX_W (RIDX_W),
    .LANE_W (LANE_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .reg_we   (reg_we),
    .mem_addr (mem_addr),
    .reg_idx  (reg_idx)
);

// File: tb/tb_partial_word_merge.sv
module tb_partial_word_merge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] base = 32'd0;
    logic [15:0] offset = 16'd0;
    logic [4:0]  rt_idx = 5'd0;
    logic [31:0] rt_val = 32'd0;
    logic [31:0] mem_addr, mem_wdata, reg_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_rd, mem_wr, reg_we, busy, done;
    logic [4:0]  reg_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    partial_word_merge dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base(base),
        .offset(offset), .rt_idx(rt_idx), .rt_val(rt_val),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    // Bench memory driven by the design's port, and the model's own copy.
    logic [31:0] mem [64];
    logic [31:0] mdl_mem [64];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
        if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    end

    function automatic logic [31:0] calc(input logic [1:0] o, input logic [1:0] k,
                                         input logic [31:0] r, input logic [31:0] m);
        int s;
        logic [31:0] ones;
        ones = 32'hFFFF_FFFF;
        case (o)
            2'd0: begin s = (3 - int'(k)) * 8; return (m << s) | (r & ~(ones << s)); end
            2'd1: begin s = int'(k) * 8;       return (m >> s) | (r & ~(ones >> s)); end
            2'd2: begin s = (3 - int'(k)) * 8; return (m & ~(ones >> s)) | (r >> s); end
            default: begin s = int'(k) * 8;    return (m & ~(ones << s)) | (r << s); end
        endcase
    endfunction

    function automatic string req_for(input logic [1:0] o);
        case (o)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int          ph = 0;
    logic [1:0]  m_op = 2'd0;
    logic [31:0] m_ea = 32'd0, m_rt = 32'd0, m_res = 32'd0;
    logic [4:0]  m_idx = 5'd0;

    always @(posedge clk) begin
        if (!rst_n) ph = 0;
        else begin
            case (ph)
                0: if (start) begin
                    m_op  = op;
                    m_ea  = base + {{16{offset[15]}}, offset};
                    m_idx = rt_idx;
                    m_rt  = rt_val;
                    ph    = 1;
                end
                1: begin
                    m_res = calc(m_op, m_ea[1:0], m_rt, mdl_mem[m_ea[7:2]]);
                    ph    = 2;
                end
                2: begin
                    if (m_op[1]) begin
                        mdl_mem[m_ea[7:2]] = m_res;
                        ph = 3;
                    end else ph = 0;
                end
                default: ph = 0;
            endcase
        end
    end

    // Per-cycle comparison on the falling edge.
    logic [31:0] obs_reg = 32'd0, obs_wr = 32'd0;
    int          n_rd = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_we, exp_done;
            exp_we   = (ph == 2) && !m_op[1] && (m_idx != 5'd0);
            exp_done = ((ph == 2) && !m_op[1]) || (ph == 3);
            chk(32'(busy), 32'(ph != 0), "R2", "busy");
            chk(32'(mem_rd), 32'(ph == 1), "R1", "mem_rd");
            if (ph == 1) chk(mem_addr, {m_ea[31:2], 2'b00}, "R1", "read address");
            chk(32'(mem_wr), 32'(ph == 3), "R9", "mem_wr");
            if (ph == 3) begin
                chk(mem_addr, {m_ea[31:2], 2'b00}, "R9", "write address");
                chk(mem_wdata, m_res, req_for(m_op), "store word");
            end
            chk(32'(reg_we), 32'(exp_we), (m_idx == 5'd0) ? "R8" : "R7", "reg_we");
            if (exp_we) begin
                chk(32'(reg_idx), 32'(m_idx), "R7", "reg_idx");
                chk(reg_wdata, m_res, req_for(m_op), "load value");
            end
            chk(32'(done), 32'(exp_done), m_op[1] ? "R9" : "R7", "done");
            if (reg_we) obs_reg = reg_wdata;
            if (mem_wr) obs_wr = mem_wdata;
            if (mem_rd) n_rd++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: cycles=%0d expected<=20000", cyc);
            report();
            $finish;
        end
    end

    task automatic poke(input int idx, input logic [31:0] v);
        mem[idx] = v;
        mdl_mem[idx] = v;
    endtask

    // Issue one request; with hold set, start stays high with junk fields
    // through the busy period including the completion cycle.
    task automatic issue(input logic [1:0] o, input logic [31:0] b, input logic [15:0] off,
                         input logic [4:0] idx, input logic [31:0] r, input bit hold);
        @(negedge clk);
        op = o; base = b; offset = off; rt_idx = idx; rt_val = r; start = 1'b1;
        repeat (o[1] ? 3 : 2) begin
            @(negedge clk);
            if (hold) begin
                start = 1'b1; op = 2'($urandom); base = $urandom;
                offset = 16'($urandom); rt_idx = 5'($urandom); rt_val = $urandom;
            end else start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) poke(i, 32'h0101_0101 * i);
        repeat (3) @(negedge clk);
        // R10: quiet outputs under reset.
        chk(32'({busy, done, mem_rd, mem_wr, reg_we}), 32'd0, "R10", "outputs in reset");
        rst_n = 1'b1;

        // Directed cases with hand-computed results.
        poke(4, 32'h4433_2211);
        issue(2'd0, 32'h0000_0010, 16'd0, 5'd3, 32'hAABB_CCDD, 1'b0);
        chk(obs_reg, 32'h11BB_CCDD, "R3", "load-left k=0");
        issue(2'd1, 32'h0000_0013, 16'd0, 5'd3, 32'hAABB_CCDD, 1'b0);
        chk(obs_reg, 32'hAABB_CC44, "R4", "load-right k=3");
        issue(2'd2, 32'h0000_0014, 16'hFFFC, 5'd3, 32'hAABB_CCDD, 1'b0);
        chk(obs_wr, 32'h4433_22AA, "R5", "store-left k=0 negative offset");
        poke(4, 32'h4433_2211);
        issue(2'd3, 32'h0000_0011, 16'd2, 5'd3, 32'hAABB_CCDD, 1'b0);
        chk(obs_wr, 32'hDD33_2211, "R6", "store-right k=3");

        // R8: index 0 load completes without a register write.
        obs_reg = 32'hDEAD_BEEF;
        issue(2'd0, 32'h0000_0020, 16'd1, 5'd0, 32'h1234_5678, 1'b0);
        chk(obs_reg, 32'hDEAD_BEEF, "R8", "no write to index 0");

        // R2: start held through busy and completion cycles.
        n_rd = 0;
        issue(2'd3, 32'h0000_0030, 16'd1, 5'd7, 32'hCAFE_F00D, 1'b1);
        chk(32'(n_rd), 32'd1, "R2", "reads for one held store");
        n_rd = 0;
        issue(2'd1, 32'h0000_0030, 16'd2, 5'd9, 32'h0BAD_F00D, 1'b1);
        chk(32'(n_rd), 32'd1, "R2", "reads for one held load");

        // R1, R3-R6: every op against every lane offset.
        for (int o = 0; o < 4; o++)
            for (int k = 0; k < 4; k++)
                issue(2'(o), 32'h1000_0040, 16'(k), 5'd5, 32'h8877_6655 + k, 1'b0);

        // Mixed random traffic.
        for (int n = 0; n < 300; n++)
            issue(2'($urandom), $urandom, 16'($urandom), 5'($urandom), $urandom,
                  1'($urandom));

        repeat (3) @(negedge clk);
        report();
        $finish;
    end
endmodule